// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Bank

This block holds the digital state behind a two-channel voltage-output converter. Each channel keeps a staging register and a live register, each 12 bits wide. Decoded serial commands arrive as a one-cycle strobe with an operation code, a channel-select mask and a payload. The block carries them out and presents one output code per channel, together with a shutdown mode and a fast-settling flag for each channel.

A set of active-low control lines comes from the programmable I/O logic. These lines can force the output codes, choose which register is shown, hold software shutdown off, impose a hardware shutdown, or force fast settling. None of them changes the stored registers, so the commanded state returns once the lines are released. A three-level strap picks the value that both registers of both channels take at reset.

Top module: `dual_dac_bank`

## Requirements
- R1: While `rst_n` is low, the staging and live registers of both channels load zero when `strap_lvl` is 2'b00, full scale (0xFFF) when it is 2'b01, and midscale (0x800) when it is 2'b10 or 2'b11. Reset also clears the shutdown codes to normal and the speed bits to slow.
- R2: Operation 4'h1 loads the payload into the staging register of every channel whose `cmd_sel` bit is 1 (bit i is channel i). It leaves live registers and unselected channels unchanged.
- R3: Operation 4'h2 loads the payload into the live register only. Operation 4'h3 loads it into both registers of each selected channel.
- R4: Operation 4'h4 copies the staging register into the live register of each channel whose select bit is 1. Channels whose bit is 0 are left unchanged.
- R5: While `ldac_n` is low, each live register takes the staging value at every clock, including a staging value written in that same cycle. While `ldac_n` is high, the live register changes only by command.
- R6: `clr_n` low forces every output code to zero, `mid_n` low forces 0x800, and `set_n` low forces 0xFFF, in the priority clr over mid over set. The stored registers are not altered.
- R7: With no force active, `tog_sel` high presents the live register and `tog_sel` low presents the staging register. Channel i appears on `out_code[12*i +: 12]`.
- R8: Operation 4'h5 stores payload bits [1:0] as the channel's shutdown code: 00 is normal, 01 is 100k termination and 11 is 1k termination. Code 10 is ignored and keeps the previous code. `sd_mode[2*i +: 2]` reports 00 for running, 01 for 1k and 10 for 100k.
- R9: `pdl_n` low reports running whatever the stored shutdown code is. When it returns high, the stored code applies again.
- R10: `shdn1k_n` low reports 1k shutdown. Otherwise `shdn100k_n` low reports 100k shutdown. Both override the stored code and `pdl_n`.
- R11: Operation 4'h6 stores payload bit 0 as the channel's speed bit (1 fast, 0 slow). `fast_en[i]` is the speed bit, or 1 for both channels while `fast_n` is low.
- R12: Strobes with any other operation code, and cycles without a strobe, leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_lvl | input | 2 | Reset-value strap: 00 zero, 01 full, 1x midscale |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 4 | Operation code |
| cmd_sel | input | 2 | Channel-select mask, bit i for channel i |
| cmd_data | input | 12 | Command payload |
| ldac_n | input | 1 | Low: live registers follow staging registers |
| set_n | input | 1 | Low: force full scale |
| mid_n | input | 1 | Low: force midscale |
| clr_n | input | 1 | Low: force zero |
| tog_sel | input | 1 | High: show live register, low: show staging register |
| pdl_n | input | 1 | Low: suppress software shutdown |
| shdn1k_n | input | 1 | Low: force 1k shutdown |
| shdn100k_n | input | 1 | Low: force 100k shutdown |
| fast_n | input | 1 | Low: force fast settling on both channels |
| out_code | output | 24 | Presented codes, channel i at [12*i +: 12] |
| sd_mode | output | 4 | Shutdown mode, channel i at [2*i +: 2] |
| fast_en | output | 2 | Fast-settling flag per channel |

## Verification
The bench builds the block with its default values: two channels and 12-bit codes. At these values both bits of the select mask can be exercised, so the copy and write operations are seen with one channel hit and the other spared. The force codes of zero, 0x800 and 0xFFF are exact, and random payloads cover the full 12-bit range. All three strap levels are applied through separate resets, and a random phase runs overlapping forces, transparency and commands against a reference model.

// File: rtl/dacbank_pkg.sv
// Shared operation codes and encodings for the converter code bank.
package dacbank_pkg;

    // Operation codes carried by the command strobe.
    typedef enum logic [3:0] {
        OP_NOP     = 4'h0,
        OP_WR_IN   = 4'h1,
        OP_WR_DAC  = 4'h2,
        OP_WR_BOTH = 4'h3,
        OP_COPY    = 4'h4,
        OP_PDSET   = 4'h5,
        OP_SPDSET  = 4'h6
    } op_e;

    // Reported shutdown mode.
    typedef enum logic [1:0] {
        SD_RUN  = 2'b00,
        SD_1K   = 2'b01,
        SD_100K = 2'b10
    } sd_e;

    // Stored software shutdown codes.
    localparam logic [1:0] PD_RUN  = 2'b00;
    localparam logic [1:0] PD_100K = 2'b01;
    localparam logic [1:0] PD_SKIP = 2'b10;
    localparam logic [1:0] PD_1K   = 2'b11;

    // Strap levels.
    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_HIGH = 2'b01;

endpackage

// File: rtl/dacbank_chan.sv
// One channel's storage: staging register, live register, shutdown code
// and speed bit. Assumes the strobe and its fields are already qualified
// by this channel's select bit and synchronous to clk.
module dacbank_chan
    import dacbank_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rst_val,
    input  logic          hit,
    input  logic [3:0]    op,
    input  logic [DW-1:0] data,
    input  logic          ldac_n,
    output logic [DW-1:0] inp_q,
    output logic [DW-1:0] dac_q,
    output logic [1:0]    pd_q,
    output logic          spd_q
);

    logic [DW-1:0] inp_d;
    logic [DW-1:0] dac_d;
    logic [1:0]    pd_d;
    logic          spd_d;

    // Next-state selection for the four stored fields.
    always_comb begin
        inp_d = inp_q;
        dac_d = dac_q;
        pd_d  = pd_q;
        spd_d = spd_q;
        if (hit) begin
            case (op)
                OP_WR_IN:   inp_d = data;
                OP_WR_DAC:  dac_d = data;
                OP_WR_BOTH: begin
                    inp_d = data;
                    dac_d = data;
                end
                OP_COPY:    dac_d = inp_q;
                OP_PDSET:   if (data[1:0] != PD_SKIP) pd_d = data[1:0];
                OP_SPDSET:  spd_d = data[0];
                default:    ;
            endcase
        end
        if (!ldac_n) begin
            dac_d = inp_d;
        end
    end

    // State registers with strap-chosen reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inp_q <= rst_val;
            dac_q <= rst_val;
            pd_q  <= PD_RUN;
            spd_q <= 1'b0;
        end else begin
            inp_q <= inp_d;
            dac_q <= dac_d;
            pd_q  <= pd_d;
            spd_q <= spd_d;
        end
    end

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (inp_q == $past(rst_val)) && (dac_q == $past(rst_val)) && (pd_q == PD_RUN)); // R1
    AST_IN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_WR_IN && ldac_n) |=> $stable(dac_q)); // R2
    AST_BOTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_WR_BOTH) |=> (inp_q == $past(data)) && (dac_q == $past(data))); // R3
    AST_COPY_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_COPY && ldac_n) |=> dac_q == $past(inp_q)); // R4
    AST_LDAC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n |=> dac_q == inp_q); // R5
    AST_PD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_PDSET && data[1:0] == PD_SKIP) |=> $stable(pd_q)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && ldac_n) |=> $stable(inp_q) && $stable(dac_q) && $stable(pd_q) && $stable(spd_q)); // R12

endmodule

// File: rtl/dacbank_view.sv
// One channel's presentation stage: applies forces and the register
// choice to the code, and resolves shutdown and speed overrides.
// Assumes the control lines are synchronous to clk; the clock and reset
// only qualify the checks.
module dacbank_view
    import dacbank_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] inp_q,
    input  logic [DW-1:0] dac_q,
    input  logic [1:0]    pd_q,
    input  logic          spd_q,
    input  logic          set_n,
    input  logic          mid_n,
    input  logic          clr_n,
    input  logic          tog_sel,
    input  logic          pdl_n,
    input  logic          shdn1k_n,
    input  logic          shdn100k_n,
    input  logic          fast_n,
    output logic [DW-1:0] code,
    output logic [1:0]    sd,
    output logic          fast
);

    localparam logic [DW-1:0] CODE_ZERO = '0;
    localparam logic [DW-1:0] CODE_MID  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] CODE_FULL = '1;

    // Output code: forces by priority, then register choice.
    always_comb begin
        if (!clr_n)      code = CODE_ZERO;
        else if (!mid_n) code = CODE_MID;
        else if (!set_n) code = CODE_FULL;
        else if (tog_sel) code = dac_q;
        else             code = inp_q;
    end

    // Shutdown mode: hardware lines, then lockout, then stored code.
    always_comb begin
        if (!shdn1k_n)        sd = SD_1K;
        else if (!shdn100k_n) sd = SD_100K;
        else if (!pdl_n)      sd = SD_RUN;
        else begin
            case (pd_q)
                PD_1K:   sd = SD_1K;
                PD_100K: sd = SD_100K;
                default: sd = SD_RUN;
            endcase
        end
    end

    // Settling speed: pin forces fast, else the stored bit.
    always_comb fast = !fast_n || spd_q;

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> code == CODE_ZERO); // R6
    AST_MID_OVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !mid_n) |-> code == CODE_MID); // R6
    AST_TOG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && mid_n && set_n && tog_sel) |-> code == dac_q); // R7
    AST_PDL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdl_n && shdn1k_n && shdn100k_n) |-> sd == SD_RUN); // R9
    AST_SHDN1K: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn1k_n |-> sd == SD_1K); // R10
    AST_FAST_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_n |-> fast); // R11

endmodule

// File: rtl/dual_dac_bank.sv
// Top of the converter code bank: decodes the strap into a reset value,
// qualifies the command strobe per channel and replicates storage and
// presentation for each channel. Assumes commands and control lines
// are synchronous to clk.
module dual_dac_bank
    import dacbank_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        strap_lvl,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [NCH-1:0]    cmd_sel,
    input  logic [DW-1:0]     cmd_data,
    input  logic              ldac_n,
    input  logic              set_n,
    input  logic              mid_n,
    input  logic              clr_n,
    input  logic              tog_sel,
    input  logic              pdl_n,
    input  logic              shdn1k_n,
    input  logic              shdn100k_n,
    input  logic              fast_n,
    output logic [NCH*DW-1:0] out_code,
    output logic [2*NCH-1:0]  sd_mode,
    output logic [NCH-1:0]    fast_en
);

    localparam logic [DW-1:0] RST_ZERO = '0;
    localparam logic [DW-1:0] RST_MID  = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] RST_FULL = '1;

    logic [DW-1:0] rst_val;

    // Strap decode: low, high, or floating (midscale).
    always_comb begin
        case (strap_lvl)
            STRAP_LOW:  rst_val = RST_ZERO;
            STRAP_HIGH: rst_val = RST_FULL;
            default:    rst_val = RST_MID;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [DW-1:0] inp_q;
        logic [DW-1:0] dac_q;
        logic [1:0]    pd_q;
        logic          spd_q;
        logic          hit;

        // Strobe qualified by this channel's select bit.
        always_comb hit = cmd_valid && cmd_sel[ch];

        dacbank_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val (rst_val),
            .hit     (hit),
            .op      (cmd_code),
            .data    (cmd_data),
            .ldac_n  (ldac_n),
            .inp_q   (inp_q),
            .dac_q   (dac_q),
            .pd_q    (pd_q),
            .spd_q   (spd_q)
        );

        dacbank_view #(.DW(DW)) u_view (
            .clk        (clk),
            .rst_n      (rst_n),
            .inp_q      (inp_q),
            .dac_q      (dac_q),
            .pd_q       (pd_q),
            .spd_q      (spd_q),
            .set_n      (set_n),
            .mid_n      (mid_n),
            .clr_n      (clr_n),
            .tog_sel    (tog_sel),
            .pdl_n      (pdl_n),
            .shdn1k_n   (shdn1k_n),
            .shdn100k_n (shdn100k_n),
            .fast_n     (fast_n),
            .code       (out_code[DW*ch +: DW]),
            .sd         (sd_mode[2*ch +: 2]),
            .fast       (fast_en[ch])
        );
    end

endmodule

// File: tb/tb_dual_dac_bank.sv
module tb_dual_dac_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap_lvl = 2'b10;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = 4'h0;
    logic [1:0]  cmd_sel = 2'b00;
    logic [11:0] cmd_data = 12'h000;
    logic        ldac_n = 1'b1, set_n = 1'b1, mid_n = 1'b1, clr_n = 1'b1;
    logic        tog_sel = 1'b1, pdl_n = 1'b1, shdn1k_n = 1'b1, shdn100k_n = 1'b1, fast_n = 1'b1;
    logic [23:0] out_code;
    logic [3:0]  sd_mode;
    logic [1:0]  fast_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [11:0] m_inp [2];
    logic [11:0] m_dac [2];
    logic [1:0]  m_pd  [2];
    logic        m_spd [2];

    always #10 clk = ~clk;

    dual_dac_bank dut (
        .clk(clk), .rst_n(rst_n), .strap_lvl(strap_lvl), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_sel(cmd_sel), .cmd_data(cmd_data), .ldac_n(ldac_n),
        .set_n(set_n), .mid_n(mid_n), .clr_n(clr_n), .tog_sel(tog_sel), .pdl_n(pdl_n),
        .shdn1k_n(shdn1k_n), .shdn100k_n(shdn100k_n), .fast_n(fast_n),
        .out_code(out_code), .sd_mode(sd_mode), .fast_en(fast_en)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] exp_code(int ch);
        if (!clr_n) return 12'h000;
        if (!mid_n) return 12'h800;
        if (!set_n) return 12'hFFF;
        return tog_sel ? m_dac[ch] : m_inp[ch];
    endfunction

    function automatic logic [1:0] exp_sd(int ch);
        if (!shdn1k_n) return 2'b01;
        if (!shdn100k_n) return 2'b10;
        if (!pdl_n) return 2'b00;
        if (m_pd[ch] == 2'b11) return 2'b01;
        if (m_pd[ch] == 2'b01) return 2'b10;
        return 2'b00;
    endfunction

    // Compare all outputs against the model for the current inputs.
    task automatic check_all();
        for (int ch = 0; ch < 2; ch++) begin
            string rc;
            string rs;
            rc = (!clr_n || !mid_n || !set_n) ? "R6" : (!tog_sel ? "R7" : "R3");
            rs = (!shdn1k_n || !shdn100k_n) ? "R10" : (!pdl_n ? "R9" : "R8");
            chk(rc, out_code[12*ch +: 12], exp_code(ch));
            chk(rs, sd_mode[2*ch +: 2], exp_sd(ch));
            chk("R11", fast_en[ch], !fast_n || m_spd[ch]);
        end
    endtask

    // Check current outputs, clock once, update the model, drop the strobe.
    task automatic step();
        logic [11:0] ni [2];
        logic [11:0] nd [2];
        #1 check_all();
        for (int ch = 0; ch < 2; ch++) begin
            bit hit;
            hit = cmd_valid && cmd_sel[ch];
            ni[ch] = m_inp[ch];
            nd[ch] = m_dac[ch];
            if (hit && (cmd_code == 4'h1 || cmd_code == 4'h3)) ni[ch] = cmd_data;
            if (hit && (cmd_code == 4'h2 || cmd_code == 4'h3)) nd[ch] = cmd_data;
            if (hit && cmd_code == 4'h4) nd[ch] = m_inp[ch];
            if (!ldac_n) nd[ch] = ni[ch];
            if (hit && cmd_code == 4'h5 && cmd_data[1:0] != 2'b10) m_pd[ch] = cmd_data[1:0];
            if (hit && cmd_code == 4'h6) m_spd[ch] = cmd_data[0];
        end
        @(posedge clk);
        for (int ch = 0; ch < 2; ch++) begin
            m_inp[ch] = ni[ch];
            m_dac[ch] = nd[ch];
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic issue(logic [3:0] code, logic [1:0] sel, logic [11:0] data);
        cmd_valid = 1'b1;
        cmd_code = code;
        cmd_sel = sel;
        cmd_data = data;
        step();
    endtask

    // Reset with a strap level and check the R1 state.
    task automatic do_reset(logic [1:0] lvl, logic [11:0] val);
        rst_n = 1'b0;
        strap_lvl = lvl;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int ch = 0; ch < 2; ch++) begin
            m_inp[ch] = val;
            m_dac[ch] = val;
            m_pd[ch] = 2'b00;
            m_spd[ch] = 1'b0;
        end
        #1;
        for (int ch = 0; ch < 2; ch++) begin
            chk("R1", out_code[12*ch +: 12], val);
            chk("R1", sd_mode[2*ch +: 2], 2'b00);
            chk("R1", fast_en[ch], 1'b0);
        end
        tog_sel = 1'b0;
        #1 chk("R1", out_code[11:0], val);
        tog_sel = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset(2'b00, 12'h000);
        do_reset(2'b01, 12'hFFF);
        do_reset(2'b10, 12'h800);

        // R2: staging-only write on channel 0
        issue(4'h1, 2'b01, 12'h123);
        #1 chk("R2", out_code[11:0], 12'h800);
        tog_sel = 1'b0;
        #1 chk("R2", out_code[11:0], 12'h123);
        chk("R2", out_code[23:12], 12'h800);
        tog_sel = 1'b1;
        // R4: copy only on the selected channel
        issue(4'h4, 2'b01, 12'h000);
        #1 chk("R4", out_code[11:0], 12'h123);
        chk("R4", out_code[23:12], 12'h800);
        // R3: live-only write on channel 1
        issue(4'h2, 2'b10, 12'h0AB);
        #1 chk("R3", out_code[23:12], 12'h0AB);
        // R12: unknown code leaves state
        issue(4'hF, 2'b11, 12'h555);
        #1 chk("R12", out_code[11:0], 12'h123);
        chk("R12", out_code[23:12], 12'h0AB);
        // R5: transparency copies staging into live
        ldac_n = 1'b0;
        issue(4'h1, 2'b01, 12'h3C4);
        ldac_n = 1'b1;
        #1 chk("R5", out_code[11:0], 12'h3C4);
        chk("R5", out_code[23:12], 12'h800);
        // R8 and R9: shutdown code, ignored code, lockout
        issue(4'h5, 2'b01, 12'h003);
        #1 chk("R8", sd_mode[1:0], 2'b01);
        issue(4'h5, 2'b01, 12'h002);
        #1 chk("R8", sd_mode[1:0], 2'b01);
        pdl_n = 1'b0;
        #1 chk("R9", sd_mode[1:0], 2'b00);
        pdl_n = 1'b1;
        #1 chk("R9", sd_mode[1:0], 2'b01);
        // R6: priority with all forces low, registers kept
        clr_n = 1'b0; mid_n = 1'b0; set_n = 1'b0;
        #1 chk("R6", out_code[11:0], 12'h000);
        clr_n = 1'b1;
        #1 chk("R6", out_code[11:0], 12'h800);
        mid_n = 1'b1; set_n = 1'b1;
        #1 chk("R6", out_code[11:0], 12'h3C4);
        step();

        // Random phase against the model.
        for (int i = 0; i < 600; i++) begin
            cmd_valid  = ($urandom % 3) != 0;
            cmd_code   = 4'($urandom % 9);
            cmd_sel    = 2'($urandom);
            cmd_data   = 12'($urandom);
            ldac_n     = ($urandom % 5) != 0;
            set_n      = ($urandom % 8) != 0;
            mid_n      = ($urandom % 8) != 0;
            clr_n      = ($urandom % 8) != 0;
            tog_sel    = ($urandom % 3) != 0;
            pdl_n      = ($urandom % 6) != 0;
            shdn1k_n   = ($urandom % 8) != 0;
            shdn100k_n = ($urandom % 8) != 0;
            fast_n     = ($urandom % 6) != 0;
            step();
        end
        #1 check_all();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule